// File: doc/BRIEF.md
# System Control Coprocessor Register File

This block is the system-control coprocessor that a processor core reaches through its register-transfer instructions to and from the coprocessor. On each cycle the core may present a read strobe or a write strobe. With the strobe it gives the four fields that select a location (primary register number, secondary register number, first opcode, second opcode), a 32-bit write word and a flag that says whether the core runs in user mode. Read data and the undefined-instruction request are combinational results of the current access. Writes take effect at the next rising clock edge.

The block holds the identity words, the control word, the translation-table base, the domain access word, the fault status and fault address, the cache and TLB lockdown words, and the process ID. The fault status and both lockdown words have separate data-side and instruction-side copies. Writes to the cache-maintenance location (register 7) and the TLB-maintenance location (register 8) store nothing. Each recognised encoding instead becomes a one-cycle command pulse. The pulse carries the selector and the operand and goes to the caches and TLBs, which sit outside this block. An access the block does not define is silently dropped: it raises no exception, changes no state and reads as zero.

Top module: `sysctl_cop`

## Requirements
- R1: An access (`acc_rd` or `acc_wr` high) with `user_mode`=1 drives `undef_req` high in the same cycle. It changes no register, issues no command and reads as zero. A privileged access never raises `undef_req`.
- R2: A read of register 0 with opcode_1=0 and CRm=0 returns the cache-type word 0x0D172172 when opcode_2=1. For any other opcode_2 value it returns the identity word 0x41129200. A write to register 0 has no effect.
- R3: In the control word (register 1) only these bits are writable: 0, 1, 2, 7, 8, 9, 12, 13, 14, 30 and 31 (mask 0xC0007387). Bits 6:3 always read as 1111. All other bits read as 0.
- R4: The translation base (register 2) keeps only write bits 31:14. Bits 13:0 read as zero whatever was written.
- R5: The domain word (register 3), the fault address (register 6) and the process ID (register 13) are full 32-bit read/write registers.
- R6: Registers 5, 9 and 10 each select a data-side copy with opcode_2=0 and an instruction-side copy with opcode_2=1. The two copies are independent.
- R7: A write to register 8 with {CRm,opcode_2} equal to one of (7,0), (5,0), (5,1), (6,0) or (6,1) makes `tlb_cmd_vld` high in the cycle after the write. In that cycle `cmd_sel` = {CRm, opcode_2} (CRm in bits 6:3) and `cmd_data` = the write word.
- R8: A write to register 7 with {CRm,opcode_2} equal to one of (7,0), (5,0), (5,1), (6,0), (6,1), (10,1), (10,2), (10,4), (14,1), (14,2), (13,1) or (0,4) produces the same kind of pulse on `cache_cmd_vld`.
- R9: A write to register 7 or 8 with any other encoding produces no pulse. A read of register 7 or 8 returns zero.
- R10: An undefined access raises no exception, changes no state and reads as zero. Undefined accesses are:
  - any access with opcode_1≠0;
  - any access to registers 4, 11, 12, 14 or 15;
  - a nonzero CRm on a storage register;
  - an opcode_2 value not listed for the register.
- R11: After reset every stored register is zero, so the control word reads 0x00000078.
- R12: Each command pulse lasts exactly one cycle. Writes in consecutive cycles give pulses in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_rd | input | 1 | Read strobe |
| acc_wr | input | 1 | Write strobe |
| crn | input | 4 | Primary register number |
| crm | input | 4 | Secondary register number |
| op1 | input | 3 | First opcode field |
| op2 | input | 3 | Second opcode field |
| wdata | input | 32 | Write word |
| user_mode | input | 1 | Core is in user mode |
| rdata | output | 32 | Read word (combinational) |
| undef_req | output | 1 | Undefined-instruction exception request |
| cache_cmd_vld | output | 1 | Cache-maintenance command pulse |
| tlb_cmd_vld | output | 1 | TLB-maintenance command pulse |
| cmd_sel | output | 7 | Command selector {CRm, opcode_2} |
| cmd_data | output | 32 | Command operand |

## Verification
The bench targets the cases where register 0 splits into two words on opcode_2. A decoder that ignored opcode_2 would return the identity word where the cache-type word is due. It writes all-ones and mixed patterns to the control word and the translation base. A wrong mask or a missing read-as-one field would show up as stray bits or lost ones. It sends user-mode writes to live locations, then reads them back in privileged mode. It also sends encodings that are one step off the maintenance tables. A design that leaked either kind of write would change a register or fire a pulse. Back-to-back maintenance writes catch a pulse stretched over two cycles or one that merges into its neighbour.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int DW = 32;
    localparam int SELW = 7;

    localparam logic [DW-1:0] CTRL_WMASK = 32'hC000_7387;
    localparam logic [DW-1:0] CTRL_ONES  = 32'h0000_0078;
    localparam logic [DW-1:0] TTB_WMASK  = 32'hFFFF_C000;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_ID, SEL_CTYPE, SEL_CTRL, SEL_TTB, SEL_DAC,
        SEL_FSR_D, SEL_FSR_I, SEL_FAR, SEL_CLK_D, SEL_CLK_I,
        SEL_TLK_D, SEL_TLK_I, SEL_PID, SEL_COP, SEL_TOP
    } sel_e;

    function automatic logic tlb_op_ok(input logic [3:0] m, input logic [2:0] o);
        case ({m, o})
            {4'd7, 3'd0}, {4'd5, 3'd0}, {4'd5, 3'd1},
            {4'd6, 3'd0}, {4'd6, 3'd1}: tlb_op_ok = 1'b1;
            default:                    tlb_op_ok = 1'b0;
        endcase
    endfunction

    function automatic logic cache_op_ok(input logic [3:0] m, input logic [2:0] o);
        case ({m, o})
            {4'd7, 3'd0}, {4'd5, 3'd0}, {4'd5, 3'd1}, {4'd6, 3'd0},
            {4'd6, 3'd1}, {4'd10, 3'd1}, {4'd10, 3'd2}, {4'd10, 3'd4},
            {4'd14, 3'd1}, {4'd14, 3'd2}, {4'd13, 3'd1},
            {4'd0, 3'd4}:  cache_op_ok = 1'b1;
            default:       cache_op_ok = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
(
    input  logic       rd,
    input  logic       wr,
    input  logic       user,
    input  logic [3:0] crn,
    input  logic [3:0] crm,
    input  logic [2:0] op1,
    input  logic [2:0] op2,
    output sel_e       sel,
    output logic       undef
);

    logic acc;
    logic plain;   // storage register with CRm=0, op2=0
    logic split;   // storage register with CRm=0, op2 picks side
    sel_e raw;

    assign acc   = rd | wr;
    assign plain = (crm == 4'd0) && (op2 == 3'd0);
    assign split = (crm == 4'd0) && (op2 <= 3'd1);

    always_comb begin
        raw = SEL_NONE;
        if (op1 == 3'd0) begin
            case (crn)
                4'd0:  if (crm == 4'd0 && !wr) raw = (op2 == 3'd1) ? SEL_CTYPE : SEL_ID;
                4'd1:  if (plain) raw = SEL_CTRL;
                4'd2:  if (plain) raw = SEL_TTB;
                4'd3:  if (plain) raw = SEL_DAC;
                4'd5:  if (split) raw = op2[0] ? SEL_FSR_I : SEL_FSR_D;
                4'd6:  if (plain) raw = SEL_FAR;
                4'd7:  if (wr && cache_op_ok(crm, op2)) raw = SEL_COP;
                4'd8:  if (wr && tlb_op_ok(crm, op2)) raw = SEL_TOP;
                4'd9:  if (split) raw = op2[0] ? SEL_CLK_I : SEL_CLK_D;
                4'd10: if (split) raw = op2[0] ? SEL_TLK_I : SEL_TLK_D;
                4'd13: if (plain) raw = SEL_PID;
                default: raw = SEL_NONE;
            endcase
        end
    end

    assign undef = acc & user;
    assign sel   = (acc && !user) ? raw : SEL_NONE;

endmodule

// File: rtl/sysctl_cmd.sv
module sysctl_cmd
    import sysctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fire_cache,
    input  logic            fire_tlb,
    input  logic [SELW-1:0] sel_in,
    input  logic [DW-1:0]   data_in,
    output logic            cache_vld,
    output logic            tlb_vld,
    output logic [SELW-1:0] sel_out,
    output logic [DW-1:0]   data_out
);

    typedef struct packed {
        logic            cvld;
        logic            tvld;
        logic [SELW-1:0] sel;
        logic [DW-1:0]   data;
    } cmd_t;

    cmd_t cmd_d, cmd_q;

    always_comb begin
        cmd_d      = cmd_q;
        cmd_d.cvld = fire_cache;
        cmd_d.tvld = fire_tlb;
        if (fire_cache || fire_tlb) begin
            cmd_d.sel  = sel_in;
            cmd_d.data = data_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cmd_q <= '0;
        else        cmd_q <= cmd_d;
    end

    assign cache_vld = cmd_q.cvld;
    assign tlb_vld   = cmd_q.tvld;
    assign sel_out   = cmd_q.sel;
    assign data_out  = cmd_q.data;

endmodule

// File: rtl/sysctl_cop.sv
module sysctl_cop
    import sysctl_pkg::*;
#(
    parameter logic [31:0] ID_WORD    = 32'h4112_9200,
    parameter logic [31:0] CTYPE_WORD = 32'h0D17_2172
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_rd,
    input  logic        acc_wr,
    input  logic [3:0]  crn,
    input  logic [3:0]  crm,
    input  logic [2:0]  op1,
    input  logic [2:0]  op2,
    input  logic [31:0] wdata,
    input  logic        user_mode,
    output logic [31:0] rdata,
    output logic        undef_req,
    output logic        cache_cmd_vld,
    output logic        tlb_cmd_vld,
    output logic [6:0]  cmd_sel,
    output logic [31:0] cmd_data
);

    typedef struct packed {
        logic [DW-1:0] ctrl;
        logic [DW-1:0] ttb;
        logic [DW-1:0] dac;
        logic [DW-1:0] fsr_d;
        logic [DW-1:0] fsr_i;
        logic [DW-1:0] far;
        logic [DW-1:0] clk_d;
        logic [DW-1:0] clk_i;
        logic [DW-1:0] tlk_d;
        logic [DW-1:0] tlk_i;
        logic [DW-1:0] pid;
    } regs_t;

    regs_t regs_d, regs_q;
    sel_e  sel;
    logic  dec_undef;
    logic [DW-1:0] rd_mux;

    sysctl_decode u_dec (
        .rd    (acc_rd),
        .wr    (acc_wr),
        .user  (user_mode),
        .crn   (crn),
        .crm   (crm),
        .op1   (op1),
        .op2   (op2),
        .sel   (sel),
        .undef (dec_undef)
    );

    always_comb begin
        regs_d = regs_q;
        if (acc_wr) begin
            case (sel)
                SEL_CTRL:  regs_d.ctrl  = wdata & CTRL_WMASK;
                SEL_TTB:   regs_d.ttb   = wdata & TTB_WMASK;
                SEL_DAC:   regs_d.dac   = wdata;
                SEL_FSR_D: regs_d.fsr_d = wdata;
                SEL_FSR_I: regs_d.fsr_i = wdata;
                SEL_FAR:   regs_d.far   = wdata;
                SEL_CLK_D: regs_d.clk_d = wdata;
                SEL_CLK_I: regs_d.clk_i = wdata;
                SEL_TLK_D: regs_d.tlk_d = wdata;
                SEL_TLK_I: regs_d.tlk_i = wdata;
                SEL_PID:   regs_d.pid   = wdata;
                default:   regs_d = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        case (sel)
            SEL_ID:    rd_mux = ID_WORD;
            SEL_CTYPE: rd_mux = CTYPE_WORD;
            SEL_CTRL:  rd_mux = regs_q.ctrl | CTRL_ONES;
            SEL_TTB:   rd_mux = regs_q.ttb;
            SEL_DAC:   rd_mux = regs_q.dac;
            SEL_FSR_D: rd_mux = regs_q.fsr_d;
            SEL_FSR_I: rd_mux = regs_q.fsr_i;
            SEL_FAR:   rd_mux = regs_q.far;
            SEL_CLK_D: rd_mux = regs_q.clk_d;
            SEL_CLK_I: rd_mux = regs_q.clk_i;
            SEL_TLK_D: rd_mux = regs_q.tlk_d;
            SEL_TLK_I: rd_mux = regs_q.tlk_i;
            SEL_PID:   rd_mux = regs_q.pid;
            default:   rd_mux = '0;
        endcase
    end

    assign rdata     = acc_rd ? rd_mux : '0;
    assign undef_req = dec_undef;

    sysctl_cmd u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire_cache (sel == SEL_COP),
        .fire_tlb   (sel == SEL_TOP),
        .sel_in     ({crm, op2}),
        .data_in    (wdata),
        .cache_vld  (cache_cmd_vld),
        .tlb_vld    (tlb_cmd_vld),
        .sel_out    (cmd_sel),
        .data_out   (cmd_data)
    );

endmodule

// File: rtl/sysctl_chk.sv
module sysctl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_rd,
    input logic        acc_wr,
    input logic [3:0]  crn,
    input logic [3:0]  crm,
    input logic [2:0]  op1,
    input logic [2:0]  op2,
    input logic [31:0] wdata,
    input logic        user_mode,
    input logic [31:0] rdata,
    input logic        undef_req,
    input logic        cache_cmd_vld,
    input logic        tlb_cmd_vld,
    input logic [6:0]  cmd_sel,
    input logic [31:0] cmd_data
);

    logic priv_rd0;
    assign priv_rd0 = acc_rd && !acc_wr && !user_mode && op1 == 3'd0 && crm == 4'd0;

    a_r1_user_undef: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd || acc_wr) && user_mode |-> undef_req);

    a_r1_priv_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !user_mode |-> !undef_req);

    a_r1_user_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr && user_mode |=> !cache_cmd_vld && !tlb_cmd_vld);

    a_r2_id_word: assert property (@(posedge clk) disable iff (!rst_n)
        priv_rd0 && crn == 4'd0 && op2 != 3'd1 |-> rdata == 32'h4112_9200);

    a_r3_ctrl_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        priv_rd0 && crn == 4'd1 && op2 == 3'd0 |-> rdata[6:3] == 4'hF && rdata[11:10] == 2'b00);

    a_r4_ttb_low: assert property (@(posedge clk) disable iff (!rst_n)
        priv_rd0 && crn == 4'd2 && op2 == 3'd0 |-> rdata[13:0] == 14'd0);

    a_r7_tlb_src: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_cmd_vld |-> $past(acc_wr && crn == 4'd8 && !user_mode && op1 == 3'd0));

    a_r8_cache_src: assert property (@(posedge clk) disable iff (!rst_n)
        cache_cmd_vld |-> $past(acc_wr && crn == 4'd7 && !user_mode && op1 == 3'd0));

    a_r7_payload: assert property (@(posedge clk) disable iff (!rst_n)
        cache_cmd_vld || tlb_cmd_vld |-> cmd_data == $past(wdata) && cmd_sel == $past({crm, op2}));

    a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cache_cmd_vld, tlb_cmd_vld}));

endmodule

bind sysctl_cop sysctl_chk u_chk (.*);

// File: tb/sim_sysctl_cop.sv
`timescale 1ns/1ps
module sim_sysctl_cop;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_rd = 1'b0, acc_wr = 1'b0, user_mode = 1'b0;
    logic [3:0]  crn = '0, crm = '0;
    logic [2:0]  op1 = '0, op2 = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, cmd_data;
    logic        undef_req, cache_cmd_vld, tlb_cmd_vld;
    logic [6:0]  cmd_sel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sysctl_cop u0 (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        acc_rd = 0; acc_wr = 0; user_mode = 0;
        crn = 0; crm = 0; op1 = 0; op2 = 0; wdata = 0;
    endtask

    // called at a falling edge; checks the combinational result, stays one cycle
    task automatic rd(input logic [3:0] n, input logic [3:0] m, input logic [2:0] o1,
                      input logic [2:0] o2, input logic usr, input logic [31:0] exp,
                      input string tag);
        acc_rd = 1; crn = n; crm = m; op1 = o1; op2 = o2; user_mode = usr;
        #2;
        chk({tag, " rdata"}, rdata, exp);
        chk({tag, " undef"}, {31'd0, undef_req}, {31'd0, usr});
        @(negedge clk);
        idle();
    endtask

    // called at a falling edge; returns at the next falling edge with pulses visible
    task automatic wr(input logic [3:0] n, input logic [3:0] m, input logic [2:0] o1,
                      input logic [2:0] o2, input logic usr, input logic [31:0] d);
        acc_wr = 1; crn = n; crm = m; op1 = o1; op2 = o2; user_mode = usr; wdata = d;
        @(negedge clk);
        idle();
    endtask

    task automatic pulse_chk(input logic c, input logic t, input logic [6:0] s,
                             input logic [31:0] d, input string tag);
        chk({tag, " cache_vld"}, {31'd0, cache_cmd_vld}, {31'd0, c});
        chk({tag, " tlb_vld"}, {31'd0, tlb_cmd_vld}, {31'd0, t});
        if (c || t) begin
            chk({tag, " sel"}, {25'd0, cmd_sel}, {25'd0, s});
            chk({tag, " data"}, cmd_data, d);
        end
    endtask

    task automatic t_reset();
        rd(4'd1, 0, 0, 0, 0, 32'h0000_0078, "R11 ctrl reset");
        rd(4'd2, 0, 0, 0, 0, 32'h0, "R11 ttb reset");
        rd(4'd13, 0, 0, 0, 0, 32'h0, "R11 pid reset");
        pulse_chk(0, 0, 0, 0, "R11 no pulse");
    endtask

    task automatic t_ident();
        rd(4'd0, 0, 0, 3'd1, 0, 32'h0D17_2172, "R2 ctype");
        rd(4'd0, 0, 0, 3'd0, 0, 32'h4112_9200, "R2 id op2=0");
        rd(4'd0, 0, 0, 3'd5, 0, 32'h4112_9200, "R2 id op2=5");
        wr(4'd0, 0, 0, 3'd0, 0, 32'hFFFF_FFFF);
        rd(4'd0, 0, 0, 3'd0, 0, 32'h4112_9200, "R2 id after write");
    endtask

    task automatic t_ctrl();
        wr(4'd1, 0, 0, 0, 0, 32'hFFFF_FFFF);
        rd(4'd1, 0, 0, 0, 0, 32'hC000_73FF, "R3 ctrl ones");
        wr(4'd1, 0, 0, 0, 0, 32'hA5A5_A5A5);
        rd(4'd1, 0, 0, 0, 0, 32'h8000_21FD, "R3 ctrl mixed");
        wr(4'd1, 0, 0, 0, 0, 32'h0);
        rd(4'd1, 0, 0, 0, 0, 32'h0000_0078, "R3 ctrl zero");
    endtask

    task automatic t_ttb();
        wr(4'd2, 0, 0, 0, 0, 32'h1234_5678);
        rd(4'd2, 0, 0, 0, 0, 32'h1234_4000, "R4 ttb mask");
        wr(4'd2, 0, 0, 0, 0, 32'h0000_3FFF);
        rd(4'd2, 0, 0, 0, 0, 32'h0, "R4 ttb low ignored");
    endtask

    task automatic t_rw();
        wr(4'd3, 0, 0, 0, 0, 32'hDEAD_BEEF);
        wr(4'd6, 0, 0, 0, 0, 32'h0BAD_F00D);
        wr(4'd13, 0, 0, 0, 0, 32'hFE00_0001);
        rd(4'd3, 0, 0, 0, 0, 32'hDEAD_BEEF, "R5 dac");
        rd(4'd6, 0, 0, 0, 0, 32'h0BAD_F00D, "R5 far");
        rd(4'd13, 0, 0, 0, 0, 32'hFE00_0001, "R5 pid");
    endtask

    task automatic t_split();
        for (int n = 0; n < 3; n++) begin
            logic [3:0] r;
            r = (n == 0) ? 4'd5 : (n == 1) ? 4'd9 : 4'd10;
            wr(r, 0, 0, 3'd0, 0, 32'h1111_0000 + 32'(n));
            wr(r, 0, 0, 3'd1, 0, 32'h2222_0000 + 32'(n));
            rd(r, 0, 0, 3'd0, 0, 32'h1111_0000 + 32'(n), "R6 data side");
            rd(r, 0, 0, 3'd1, 0, 32'h2222_0000 + 32'(n), "R6 instr side");
        end
    endtask

    task automatic t_tlb();
        logic [3:0] ms [5] = '{4'd7, 4'd5, 4'd5, 4'd6, 4'd6};
        logic [2:0] os [5] = '{3'd0, 3'd0, 3'd1, 3'd0, 3'd1};
        for (int i = 0; i < 5; i++) begin
            wr(4'd8, ms[i], 0, os[i], 0, 32'hC0DE_0000 + 32'(i));
            pulse_chk(0, 1, {ms[i], os[i]}, 32'hC0DE_0000 + 32'(i), "R7 tlb op");
            @(negedge clk);
            pulse_chk(0, 0, 0, 0, "R12 tlb one cycle");
        end
    endtask

    task automatic t_cache();
        logic [3:0] ms [12] = '{4'd7, 4'd5, 4'd5, 4'd6, 4'd6, 4'd10, 4'd10, 4'd10,
                                4'd14, 4'd14, 4'd13, 4'd0};
        logic [2:0] os [12] = '{3'd0, 3'd0, 3'd1, 3'd0, 3'd1, 3'd1, 3'd2, 3'd4,
                                3'd1, 3'd2, 3'd1, 3'd4};
        for (int i = 0; i < 12; i++) begin
            wr(4'd7, ms[i], 0, os[i], 0, 32'hCAC0_0000 + 32'(i));
            pulse_chk(1, 0, {ms[i], os[i]}, 32'hCAC0_0000 + 32'(i), "R8 cache op");
        end
        @(negedge clk);
        pulse_chk(0, 0, 0, 0, "R12 cache one cycle");
    endtask

    task automatic t_bad_ops();
        wr(4'd8, 4'd7, 0, 3'd1, 0, 32'h1);
        pulse_chk(0, 0, 0, 0, "R9 tlb bad op2");
        wr(4'd8, 4'd10, 0, 3'd1, 0, 32'h1);
        pulse_chk(0, 0, 0, 0, "R9 tlb cache-only enc");
        wr(4'd7, 4'd10, 0, 3'd3, 0, 32'h1);
        pulse_chk(0, 0, 0, 0, "R9 cache bad enc");
        wr(4'd7, 4'd7, 3'd1, 3'd0, 0, 32'h1);
        pulse_chk(0, 0, 0, 0, "R10 cache op1");
        rd(4'd7, 4'd7, 0, 0, 0, 32'h0, "R9 read cache reg");
        rd(4'd8, 4'd7, 0, 0, 0, 32'h0, "R9 read tlb reg");
    endtask

    task automatic t_unpred();
        wr(4'd13, 0, 0, 0, 0, 32'h0000_00AA);
        wr(4'd13, 0, 3'd2, 0, 0, 32'hFFFF_FFFF);
        wr(4'd13, 4'd1, 0, 0, 0, 32'hFFFF_FFFF);
        wr(4'd13, 0, 0, 3'd1, 0, 32'hFFFF_FFFF);
        rd(4'd13, 0, 0, 0, 0, 32'h0000_00AA, "R10 pid untouched");
        rd(4'd13, 0, 3'd2, 0, 0, 32'h0, "R10 op1 read zero");
        rd(4'd13, 4'd1, 0, 0, 0, 32'h0, "R10 crm read zero");
        rd(4'd5, 0, 0, 3'd2, 0, 32'h0, "R10 split bad op2");
        for (int r = 0; r < 5; r++) begin
            logic [3:0] n;
            n = (r == 0) ? 4'd4 : (r == 1) ? 4'd11 : (r == 2) ? 4'd12 : (r == 3) ? 4'd14 : 4'd15;
            wr(n, 0, 0, 0, 0, 32'hFFFF_FFFF);
            rd(n, 0, 0, 0, 0, 32'h0, "R10 reserved reg");
        end
        rd(4'd0, 4'd3, 0, 3'd0, 0, 32'h0, "R10 id crm nonzero");
    endtask

    task automatic t_user();
        rd(4'd0, 0, 0, 3'd0, 1, 32'h0, "R1 user read id");
        rd(4'd3, 0, 0, 0, 1, 32'h0, "R1 user read dac");
        acc_wr = 1; crn = 4'd3; user_mode = 1; wdata = 32'h5555_5555;
        #2;
        chk("R1 user write undef", {31'd0, undef_req}, 32'd1);
        @(negedge clk);
        idle();
        rd(4'd3, 0, 0, 0, 0, 32'hDEAD_BEEF, "R1 dac unchanged");
        wr(4'd8, 4'd7, 0, 3'd0, 1, 32'h7);
        pulse_chk(0, 0, 0, 0, "R1 user tlb no pulse");
        wr(4'd7, 4'd7, 0, 3'd0, 1, 32'h7);
        pulse_chk(0, 0, 0, 0, "R1 user cache no pulse");
    endtask

    task automatic t_b2b();
        acc_wr = 1; crn = 4'd8; crm = 4'd6; op2 = 3'd1; wdata = 32'hAAAA_0001;
        @(negedge clk);
        pulse_chk(0, 1, {4'd6, 3'd1}, 32'hAAAA_0001, "R12 first pulse");
        crn = 4'd7; crm = 4'd10; op2 = 3'd4; wdata = 32'hAAAA_0002;
        @(negedge clk);
        idle();
        pulse_chk(1, 0, {4'd10, 3'd4}, 32'hAAAA_0002, "R12 second pulse");
        @(negedge clk);
        pulse_chk(0, 0, 0, 0, "R12 after pair");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_ident();
        t_ctrl();
        t_ttb();
        t_rw();
        t_split();
        t_tlb();
        t_cache();
        t_bad_ops();
        t_unpred();
        t_user();
        t_b2b();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule